// File: doc/BRIEF.md
# Parallel LCD Write Sequencer

This block turns single write requests into bus cycles on an 8080-style parallel panel interface. Each request arrives over a valid/ready handshake and carries one data word and one bit that selects command or data. The block drives that bit onto the panel's address/command line. It then lowers an active-low chip-select, pulses an active-low write-enable and holds the data word on the bus until chip-select rises again.

Every bus cycle has four phases in fixed order: address setup, write setup, write active and write hold. Each phase runs for its 4-bit configuration value plus one clock, so a phase takes 1 to 16 cycles. The four timing values and the request payload are latched at the moment a request is accepted. A later change to the configuration inputs or to the request inputs has no effect on the cycle in progress. If the requester keeps `req_valid` high, transfers follow each other with one idle clock between them.

Top module: `lcd_wr_seq`

## Requirements
- R1: Out of reset, and whenever no transfer is in progress, `lcd_cs_n` and `lcd_we_n` are 1, `req_ready` is 1 and `busy` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. From the next cycle `lcd_dc` equals the accepted `req_dc` for the whole transfer. `lcd_cs_n` stays 1 for `cfg_cs_setup`+1 cycles and then falls.
- R3: After `lcd_cs_n` falls, `lcd_we_n` stays 1 for `cfg_wr_setup`+1 cycles and then falls.
- R4: `lcd_we_n` stays 0 for `cfg_wr_active`+1 cycles.
- R5: After `lcd_we_n` rises, `lcd_cs_n` stays 0 for `cfg_wr_hold`+1 cycles and then returns to 1.
- R6: `lcd_data` equals the accepted `req_data` in every cycle where `lcd_cs_n` is 0, and it does not change while `lcd_cs_n` stays 0.
- R7: The timing values and the payload are captured at acceptance. Changing `cfg_*`, `req_data` or `req_dc` during a transfer does not alter that transfer.
- R8: `req_ready` is 0 from the cycle after acceptance until `lcd_cs_n` returns to 1. A request held valid meanwhile is not taken. It is accepted on the first idle cycle, so its address phase starts in the cycle after the release cycle.
- R9: `lcd_we_n` is never 0 while `lcd_cs_n` is 1. In every transfer, `lcd_we_n` rises before `lcd_cs_n` rises.
- R10: `busy` is 1 from the cycle after acceptance through the last hold cycle, and 0 otherwise.
- R11: While `req_valid` is 0 in the idle state, the outputs keep their idle values and no transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_dc | input | 1 | Command/data select bit of the request |
| req_data | input | DATA_W | Write data word of the request |
| cfg_cs_setup | input | TIME_W | Address-to-chip-select cycles minus one |
| cfg_wr_setup | input | TIME_W | Chip-select-to-write-enable cycles minus one |
| cfg_wr_active | input | TIME_W | Write-enable low cycles minus one |
| cfg_wr_hold | input | TIME_W | Write-enable-release-to-chip-select-release cycles minus one |
| lcd_dc | output | 1 | Panel address/command line |
| lcd_cs_n | output | 1 | Panel chip-select, active low |
| lcd_we_n | output | 1 | Panel write-enable, active low |
| lcd_data | output | DATA_W | Panel data bus |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest case to reach from the ports is a transfer whose configuration and payload inputs change while it runs, with another request already waiting. A stale timing value or a leaked payload would only appear as a shifted edge or a wrong bus word several cycles later. The bench therefore inverts every `cfg_*` field and the payload right after acceptance and keeps `req_valid` high with the new request. It then compares each cycle against a trace computed from the original values. Transfers issued back to back, with all-zero and all-maximum timings, check the single idle gap and the phase limits at both ends.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ADDR   = 3'd1,
        PH_SETUP  = 3'd2,
        PH_ACTIVE = 3'd3,
        PH_HOLD   = 3'd4
    } phase_e;

    // Values held in the captured timing registers after reset
    localparam int RST_WR_SETUP  = 0;
    localparam int RST_WR_ACTIVE = 1;
    localparam int RST_WR_HOLD   = 0;

endpackage

// File: rtl/lcd_wr_phase_timer.sv
module lcd_wr_phase_timer #(
    parameter int TIME_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    output logic              done
);

    logic [TIME_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

    // Counter walks down one step per cycle unless reloaded (R2..R5 phase lengths)
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // A reload always lands the requested value (R2..R5)
    p_load_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/lcd_wr_ctrl.sv
module lcd_wr_ctrl
    import lcd_wr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TIME_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_dc,
    input  logic [DATA_W-1:0] req_data,
    input  logic [TIME_W-1:0] cfg_cs_setup,
    input  logic [TIME_W-1:0] cfg_wr_setup,
    input  logic [TIME_W-1:0] cfg_wr_active,
    input  logic [TIME_W-1:0] cfg_wr_hold,
    input  logic              tmr_done,
    output logic              tmr_load,
    output logic [TIME_W-1:0] tmr_val,
    output logic              req_ready,
    output logic              busy,
    output logic              lcd_dc,
    output logic              lcd_cs_n,
    output logic              lcd_we_n,
    output logic [DATA_W-1:0] lcd_data
);

    typedef struct packed {
        phase_e            ph;
        logic              dc;
        logic [DATA_W-1:0] data;
        logic [TIME_W-1:0] wr_setup;
        logic [TIME_W-1:0] wr_active;
        logic [TIME_W-1:0] wr_hold;
    } st_t;

    st_t st_d, st_q;
    logic accept;

    assign accept = req_valid && (st_q.ph == PH_IDLE);

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.ph        = PH_ADDR;
                    st_d.dc        = req_dc;
                    st_d.data      = req_data;
                    st_d.wr_setup  = cfg_wr_setup;
                    st_d.wr_active = cfg_wr_active;
                    st_d.wr_hold   = cfg_wr_hold;
                    tmr_load       = 1'b1;
                    tmr_val        = cfg_cs_setup;
                end
            end
            PH_ADDR: begin
                if (tmr_done) begin
                    st_d.ph  = PH_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = st_q.wr_setup;
                end
            end
            PH_SETUP: begin
                if (tmr_done) begin
                    st_d.ph  = PH_ACTIVE;
                    tmr_load = 1'b1;
                    tmr_val  = st_q.wr_active;
                end
            end
            PH_ACTIVE: begin
                if (tmr_done) begin
                    st_d.ph  = PH_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = st_q.wr_hold;
                end
            end
            PH_HOLD: begin
                if (tmr_done) begin
                    st_d.ph = PH_IDLE;
                end
            end
            default: begin
                st_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph        <= PH_IDLE;
            st_q.dc        <= 1'b0;
            st_q.data      <= '0;
            st_q.wr_setup  <= TIME_W'(RST_WR_SETUP);
            st_q.wr_active <= TIME_W'(RST_WR_ACTIVE);
            st_q.wr_hold   <= TIME_W'(RST_WR_HOLD);
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.ph == PH_IDLE);
    assign busy      = (st_q.ph != PH_IDLE);
    assign lcd_cs_n  = (st_q.ph == PH_IDLE) || (st_q.ph == PH_ADDR);
    assign lcd_we_n  = (st_q.ph != PH_ACTIVE);
    assign lcd_dc    = st_q.dc;
    assign lcd_data  = st_q.data;

    // Acceptance closes the handshake and raises busy in the next cycle (R8, R10)
    p_accept_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && !req_ready && lcd_cs_n));

    // The command/data line does not move inside a transfer (R2)
    p_dc_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lcd_dc));

    // Bus word is frozen while chip-select is low (R6)
    p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_cs_n && $past(!lcd_cs_n)) |-> $stable(lcd_data));

    // Write strobe only inside chip-select (R9)
    p_we_inside_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_we_n |-> !lcd_cs_n);

    // Write strobe already high when chip-select releases (R9)
    p_we_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_cs_n) |-> $past(lcd_we_n));

    // Chip-select falls with the write strobe still high (R3)
    p_cs_fall_we_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_cs_n) |-> lcd_we_n);

    // Chip-select release ends busy in the same cycle (R10)
    p_release_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_cs_n) |-> (!busy && req_ready));

endmodule

// File: rtl/lcd_wr_seq.sv
module lcd_wr_seq #(
    parameter int DATA_W = 16,
    parameter int TIME_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_dc,
    input  logic [DATA_W-1:0] req_data,
    input  logic [TIME_W-1:0] cfg_cs_setup,
    input  logic [TIME_W-1:0] cfg_wr_setup,
    input  logic [TIME_W-1:0] cfg_wr_active,
    input  logic [TIME_W-1:0] cfg_wr_hold,
    output logic              lcd_dc,
    output logic              lcd_cs_n,
    output logic              lcd_we_n,
    output logic [DATA_W-1:0] lcd_data,
    output logic              busy
);

    logic              tmr_load;
    logic [TIME_W-1:0] tmr_val;
    logic              tmr_done;

    lcd_wr_phase_timer #(
        .TIME_W (TIME_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    lcd_wr_ctrl #(
        .DATA_W (DATA_W),
        .TIME_W (TIME_W)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_dc        (req_dc),
        .req_data      (req_data),
        .cfg_cs_setup  (cfg_cs_setup),
        .cfg_wr_setup  (cfg_wr_setup),
        .cfg_wr_active (cfg_wr_active),
        .cfg_wr_hold   (cfg_wr_hold),
        .tmr_done      (tmr_done),
        .tmr_load      (tmr_load),
        .tmr_val       (tmr_val),
        .req_ready     (req_ready),
        .busy          (busy),
        .lcd_dc        (lcd_dc),
        .lcd_cs_n      (lcd_cs_n),
        .lcd_we_n      (lcd_we_n),
        .lcd_data      (lcd_data)
    );

    // Reset leaves the bus idle (R1)
    p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lcd_cs_n && lcd_we_n && req_ready));

endmodule

// File: tb/lcd_wr_seq_tb_top.sv
`timescale 1ns/1ps
module lcd_wr_seq_tb_top;

    localparam int DW = 16;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_dc = 1'b0;
    logic [DW-1:0] req_data = '0;
    logic [TW-1:0] cfg_cs_setup = '0;
    logic [TW-1:0] cfg_wr_setup = '0;
    logic [TW-1:0] cfg_wr_active = 4'd1;
    logic [TW-1:0] cfg_wr_hold = '0;
    logic          lcd_dc, lcd_cs_n, lcd_we_n, busy;
    logic [DW-1:0] lcd_data;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lcd_wr_seq #(.DATA_W(DW), .TIME_W(TW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_dc        (req_dc),
        .req_data      (req_data),
        .cfg_cs_setup  (cfg_cs_setup),
        .cfg_wr_setup  (cfg_wr_setup),
        .cfg_wr_active (cfg_wr_active),
        .cfg_wr_hold   (cfg_wr_hold),
        .lcd_dc        (lcd_dc),
        .lcd_cs_n      (lcd_cs_n),
        .lcd_we_n      (lcd_we_n),
        .lcd_data      (lcd_data),
        .busy          (busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Idle pins packed as {cs_n, we_n, ready, busy}; expected 4'b1110
    task automatic check_idle(input string req);
        check({lcd_cs_n, lcd_we_n, req_ready, busy} == 4'b1110, req, "idle pins",
              int'({lcd_cs_n, lcd_we_n, req_ready, busy}), 'he);
    endtask

    // One transfer; entered and left at a falling edge. With disturb the
    // config/payload inputs are inverted and a new request held valid
    // throughout the transfer (R7, R8).
    task automatic xfer(input int cs, input int ws, input int wa, input int wh,
                        input logic [DW-1:0] dat, input logic dc,
                        input bit disturb, input string req);
        int total;
        bit bad;
        int bad_k;
        logic [4:0] act_v, exp_v;
        cfg_cs_setup  = TW'(cs);
        cfg_wr_setup  = TW'(ws);
        cfg_wr_active = TW'(wa);
        cfg_wr_hold   = TW'(wh);
        req_data      = dat;
        req_dc        = dc;
        req_valid     = 1'b1;
        check(req_ready == 1'b1, "R8", "ready before accept", int'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        if (disturb) begin
            cfg_cs_setup  = ~TW'(cs);
            cfg_wr_setup  = ~TW'(ws);
            cfg_wr_active = ~TW'(wa);
            cfg_wr_hold   = ~TW'(wh);
            req_data      = ~dat;
            req_dc        = ~dc;
        end else begin
            req_valid = 1'b0;
        end
        total = cs + ws + wa + wh + 4;
        bad   = 1'b0;
        bad_k = 0;
        act_v = '0;
        exp_v = '0;
        for (int k = 0; k < total; k++) begin
            logic e_cs_n, e_we_n;
            bit d_ok;
            e_cs_n = (k < cs + 1);
            e_we_n = !((k >= cs + ws + 2) && (k < cs + ws + wa + 3));
            d_ok   = e_cs_n || (lcd_data == dat);
            if (!bad && (lcd_cs_n !== e_cs_n || lcd_we_n !== e_we_n || busy !== 1'b1 ||
                         req_ready !== 1'b0 || lcd_dc !== dc || !d_ok)) begin
                bad   = 1'b1;
                bad_k = k;
                act_v = {lcd_cs_n, lcd_we_n, busy, req_ready, lcd_dc};
                exp_v = {e_cs_n, e_we_n, 1'b1, 1'b0, dc};
                if (!d_ok) begin
                    $display("FAIL %s data at cycle %0d: actual=%0h expected=%0h",
                             req, k, lcd_data, dat);
                end
            end
            @(negedge clk);
        end
        // Trace bits {cs_n, we_n, busy, ready, dc} per cycle (R2..R6, R9, R10)
        check(!bad, req, $sformatf("trace at cycle %0d {cs_n,we_n,busy,ready,dc}", bad_k),
              int'(act_v), int'(exp_v));
        if (disturb) begin
            req_valid = 1'b0;
        end
        check_idle("R5");
    endtask

    task automatic t_reset;
        check_idle("R1");
    endtask

    task automatic t_quiet;
        req_valid = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
        end
        check_idle("R11");
    endtask

    task automatic t_default_timing;
        xfer(0, 0, 1, 0, 16'hA55A, 1'b1, 1'b0, "R4");
    endtask

    task automatic t_mixed_timing;
        xfer(3, 2, 5, 1, 16'h1234, 1'b0, 1'b0, "R3");
        xfer(1, 4, 0, 6, 16'h0F0F, 1'b1, 1'b0, "R5");
    endtask

    task automatic t_min_max;
        xfer(0, 0, 0, 0, 16'hFFFF, 1'b0, 1'b0, "R2");
        xfer(15, 15, 15, 15, 16'h8001, 1'b1, 1'b0, "R6");
    endtask

    task automatic t_capture;
        xfer(2, 1, 3, 2, 16'hC3C3, 1'b1, 1'b1, "R7");
        xfer(5, 0, 2, 3, 16'h5AA5, 1'b0, 1'b1, "R7");
    endtask

    // Next call is issued at the idle falling edge of the previous one, so any
    // extra idle cycle shows up as a trace mismatch (R8)
    task automatic t_back_to_back;
        xfer(0, 1, 1, 0, 16'h0001, 1'b0, 1'b0, "R8");
        xfer(0, 0, 0, 0, 16'h0002, 1'b1, 1'b0, "R8");
        xfer(1, 0, 2, 1, 16'h0003, 1'b0, 1'b0, "R8");
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_quiet();
        t_default_timing();
        t_mixed_timing();
        t_min_max();
        t_capture();
        t_back_to_back();
        t_quiet();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule